// File: doc/BRIEF.md
# OTP Word Programming Pulse Sequencer

This block writes one data word into a one-time-programmable memory macro for each request. Software first loads the data word and then the target word address into a one-entry request buffer. The address write starts the programming, but only while the program mode is active. The block raises the macro's program enable and waits a setup interval. It then strobes one timed pulse for every data bit that is 1, in ascending bit order, with a gap interval between pulses. After the last pulse it holds the enable, drops it and waits out a recovery interval before it accepts the next request.

All intervals are counted in microsecond ticks that a shared timebase supplies. An interval value N lasts N+1 ticks, so a cycle without a tick does not advance an interval. A two-bit array select is captured at launch and steers the program enable to the normal array, the redundancy array or both. Two flags tell software when it may load the next request: one shows that the buffer is empty and one shows that the engine is idle.

Top module: `otp_word_prog`

## Requirements
- R1: After reset, `buf_empty_o`=1, `prog_idle_o`=1, `mac_pgm_en_o`=0 and `mac_strobe_o`=0.
- R2: A data or address write is accepted only while `buf_empty_o`=1. While it is 0, writes leave `buf_data_o` and `buf_addr_o` unchanged.
- R3: An address write with `prog_mode_i`=1 and `buf_empty_o`=1 launches a request. On the next cycle `buf_empty_o`=0, `prog_idle_o`=0 and `mac_pgm_en_o`=1. With `prog_mode_i`=0 the address is stored, but there is no launch: both flags stay 1 and the enable stays 0.
- R4: After launch, the enable is high and the strobe is low for `t_setup_i`+1 ticks before the first pulse.
- R5: Every 1 bit of the data word gets exactly one strobe pulse of `t_pulse_i`+1 ticks. Pulses come in ascending bit index, and `mac_bit_o` shows that index during the pulse.
- R6: Consecutive pulses are separated by `t_gap_i`+1 ticks with the enable held high. Zero bits between them add no time.
- R7: After the last pulse, the enable stays high for `t_hold_i`+1 ticks. For an all-zero word, the hold follows the setup directly, so the enable lasts (`t_setup_i`+1)+(`t_hold_i`+1) ticks with no pulse.
- R8: The enable then falls. `prog_idle_o` stays 0 for `t_recov_i`+1 ticks, after which `prog_idle_o` and `buf_empty_o` return to 1 in the same cycle.
- R9: `arr_sel_i` is captured at launch. While the enable is high, `mac_sel_norm_o`=1 for codes 0, 1 and 3, and `mac_sel_red_o`=1 for codes 0, 2 and 3. Code 3 behaves as code 0.
- R10: An interval advances only on cycles where `tick_us_i`=1. Its length in ticks is independent of the tick spacing.
- R11: `mac_addr_o` carries the buffered word address for the whole request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode_i | input | 1 | Program mode active |
| wr_data_i | input | 1 | Write strobe for the data register |
| data_i | input | DW | Data word to program |
| wr_addr_i | input | 1 | Write strobe for the address register (launch) |
| addr_i | input | AW | Word address |
| arr_sel_i | input | 2 | Array select code |
| tick_us_i | input | 1 | Microsecond tick |
| t_setup_i | input | TW | Setup ticks minus one |
| t_pulse_i | input | TW | Pulse ticks minus one |
| t_gap_i | input | TW | Gap ticks minus one |
| t_hold_i | input | TW | Hold ticks minus one |
| t_recov_i | input | TW | Recovery ticks minus one |
| buf_empty_o | output | 1 | Request buffer empty |
| prog_idle_o | output | 1 | Engine idle |
| buf_data_o | output | DW | Buffered data readback |
| buf_addr_o | output | AW | Buffered address readback |
| mac_addr_o | output | AW | Macro word address |
| mac_bit_o | output | $clog2(DW) | Macro bit index |
| mac_strobe_o | output | 1 | Macro program strobe |
| mac_pgm_en_o | output | 1 | Macro program enable |
| mac_sel_norm_o | output | 1 | Normal array select |
| mac_sel_red_o | output | 1 | Redundancy array select |

## Verification
The launch response is due exactly one cycle after the accepted address write. The bench samples the flags and the enable at the falling edge that follows that capture edge. Interval results cannot be tied to a fixed cycle once the tick is sparse. For that reason, the bench counts the ticks it observes at each falling edge while a phase is visible on the outputs, and it compares the count with the programmed value plus one when the phase ends. The end of recovery is checked at the first falling edge where idle reads 1: both flags must rise together there.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_PULSE,
      PH_GAP,
      PH_HOLD,
      PH_RECOV
   } prog_phase_e;

   // code 3 is folded onto code 0 (both arrays)
   function automatic logic sel_normal(input logic [1:0] code);
      return code != 2'd2;
   endfunction

   function automatic logic sel_redund(input logic [1:0] code);
      return code != 2'd1;
   endfunction
endpackage

// File: rtl/otp_us_timer.sv
module otp_us_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          tick_i,
   input  logic [TW-1:0] lim_i,
   output logic          done_o
);
   logic [TW-1:0] cnt_q;

   assign done_o = tick_i && (cnt_q == lim_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr_i || done_o)  cnt_q <= '0;
      else if (tick_i)           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/otp_bit_finder.sv
module otp_bit_finder #(
   parameter int DW = 32,
   localparam int IW = $clog2(DW)
) (
   input  logic [DW-1:0] vec_i,
   output logic [DW-1:0] first_oh_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   logic [DW:0] below;

   assign below[0] = 1'b0;
   for (genvar g = 0; g < DW; g++) begin : g_chain
      assign first_oh_o[g] = vec_i[g] & ~below[g];
      assign below[g+1]    = below[g] | vec_i[g];
   end
   assign any_o = below[DW];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < DW; i++)
         if (first_oh_o[i]) idx_o = idx_o | IW'(i);
   end
endmodule

// File: rtl/otp_req_buffer.sv
module otp_req_buffer #(
   parameter int DW = 32,
   parameter int AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data_i,
   input  logic [DW-1:0] data_i,
   input  logic          wr_addr_i,
   input  logic [AW-1:0] addr_i,
   input  logic          mode_i,
   input  logic          done_i,
   output logic [DW-1:0] data_o,
   output logic [AW-1:0] addr_o,
   output logic          empty_o,
   output logic          launch_o
);
   logic [DW-1:0] data_q;
   logic [AW-1:0] addr_q;
   logic          empty_q;

   assign launch_o = wr_addr_i && empty_q && mode_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         addr_q  <= '0;
         empty_q <= 1'b1;
      end else begin
         if (wr_data_i && empty_q) data_q <= data_i;
         if (wr_addr_i && empty_q) addr_q <= addr_i;
         if (launch_o)             empty_q <= 1'b0;
         else if (done_i)          empty_q <= 1'b1;
      end
   end

   assign data_o  = data_q;
   assign addr_o  = addr_q;
   assign empty_o = empty_q;

   // R2: a full buffer ignores writes
   p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_q |=> ($stable(data_q) && $stable(addr_q)));
endmodule

// File: rtl/otp_word_prog.sv
module otp_word_prog
   import otp_prog_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 13,
   parameter int TW = 8,
   localparam int IW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_mode_i,
   input  logic          wr_data_i,
   input  logic [DW-1:0] data_i,
   input  logic          wr_addr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    arr_sel_i,
   input  logic          tick_us_i,
   input  logic [TW-1:0] t_setup_i,
   input  logic [TW-1:0] t_pulse_i,
   input  logic [TW-1:0] t_gap_i,
   input  logic [TW-1:0] t_hold_i,
   input  logic [TW-1:0] t_recov_i,
   output logic          buf_empty_o,
   output logic          prog_idle_o,
   output logic [DW-1:0] buf_data_o,
   output logic [AW-1:0] buf_addr_o,
   output logic [AW-1:0] mac_addr_o,
   output logic [IW-1:0] mac_bit_o,
   output logic          mac_strobe_o,
   output logic          mac_pgm_en_o,
   output logic          mac_sel_norm_o,
   output logic          mac_sel_red_o
);
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (TW < 7) begin : g_bad_tw
      $error("TW must hold a 100 us interval");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be positive");
   end

   prog_phase_e   phase_q;
   logic [DW-1:0] remain_q;
   logic [IW-1:0] bit_q;
   logic [1:0]    sel_q;
   logic          launch, seq_done, ph_done;
   logic [TW-1:0] lim;
   logic [DW-1:0] scan_vec, first_oh;
   logic [IW-1:0] first_idx;
   logic          scan_any;

   otp_req_buffer #(.DW(DW), .AW(AW)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_data_i(wr_data_i), .data_i(data_i),
      .wr_addr_i(wr_addr_i), .addr_i(addr_i),
      .mode_i(prog_mode_i), .done_i(seq_done),
      .data_o(buf_data_o), .addr_o(buf_addr_o),
      .empty_o(buf_empty_o), .launch_o(launch)
   );

   always_comb begin
      unique case (phase_q)
         PH_SETUP: lim = t_setup_i;
         PH_PULSE: lim = t_pulse_i;
         PH_GAP:   lim = t_gap_i;
         PH_HOLD:  lim = t_hold_i;
         PH_RECOV: lim = t_recov_i;
         default:  lim = '0;
      endcase
   end

   otp_us_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(launch),
      .tick_i(tick_us_i), .lim_i(lim), .done_o(ph_done)
   );

   // the first scan uses the stored word, later scans use the leftover bits
   assign scan_vec = (phase_q == PH_SETUP) ? buf_data_o : remain_q;

   otp_bit_finder #(.DW(DW)) u_find (
      .vec_i(scan_vec), .first_oh_o(first_oh),
      .idx_o(first_idx), .any_o(scan_any)
   );

   assign seq_done = (phase_q == PH_RECOV) && ph_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         remain_q <= '0;
         bit_q    <= '0;
         sel_q    <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (launch) begin
               phase_q <= PH_SETUP;
               sel_q   <= arr_sel_i;
            end
            PH_SETUP, PH_GAP: if (ph_done) begin
               if (scan_any) begin
                  phase_q  <= PH_PULSE;
                  bit_q    <= first_idx;
                  remain_q <= scan_vec & ~first_oh;
               end else begin
                  phase_q  <= PH_HOLD;
               end
            end
            PH_PULSE: if (ph_done) phase_q <= (remain_q != '0) ? PH_GAP : PH_HOLD;
            PH_HOLD:  if (ph_done) phase_q <= PH_RECOV;
            PH_RECOV: if (ph_done) phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   assign prog_idle_o    = (phase_q == PH_IDLE);
   assign mac_strobe_o   = (phase_q == PH_PULSE);
   assign mac_pgm_en_o   = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) ||
                           (phase_q == PH_GAP)   || (phase_q == PH_HOLD);
   assign mac_bit_o      = bit_q;
   assign mac_addr_o     = buf_addr_o;
   assign mac_sel_norm_o = mac_pgm_en_o && sel_normal(sel_q);
   assign mac_sel_red_o  = mac_pgm_en_o && sel_redund(sel_q);

   // R3: an accepted launch raises enable and clears both flags next cycle
   p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr_i && buf_empty_o && prog_mode_i) |=>
      (mac_pgm_en_o && !prog_idle_o && !buf_empty_o));
   // R5: a strobe only occurs under enable, and only on a bit that is 1
   p_strobe_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mac_strobe_o |-> mac_pgm_en_o);
   p_bit_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mac_strobe_o |-> buf_data_o[mac_bit_o]);
   // R9: some array is always selected while programming
   p_sel_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mac_pgm_en_o |-> (mac_sel_norm_o || mac_sel_red_o));
   // R11: the address holds throughout a request
   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_idle_o && $past(!prog_idle_o)) |-> $stable(mac_addr_o));
endmodule

// File: tb/otp_word_prog_tb.sv
module otp_word_prog_tb;
   localparam int DW = 32, AW = 13, TW = 8, IW = $clog2(DW);

   logic clk = 0, rst_n = 0;
   logic prog_mode = 0, wr_data = 0, wr_addr = 0, tick = 0;
   logic [DW-1:0] data_v = '0;
   logic [AW-1:0] addr_v = '0;
   logic [1:0] sel_v = '0;
   logic [TW-1:0] ts = 0, tp = 0, tg = 0, th = 0, tr = 0;
   logic buf_empty, idle, strobe, pgm_en, s_norm, s_red;
   logic [DW-1:0] bdata;
   logic [AW-1:0] baddr, maddr;
   logic [IW-1:0] mbit;
   int nchk = 0, nfail = 0, tper = 1, tcnt = 0, cycles = 0;

   always #10 clk = ~clk;

   otp_word_prog #(.DW(DW), .AW(AW), .TW(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .prog_mode_i(prog_mode),
      .wr_data_i(wr_data), .data_i(data_v), .wr_addr_i(wr_addr), .addr_i(addr_v),
      .arr_sel_i(sel_v), .tick_us_i(tick),
      .t_setup_i(ts), .t_pulse_i(tp), .t_gap_i(tg), .t_hold_i(th), .t_recov_i(tr),
      .buf_empty_o(buf_empty), .prog_idle_o(idle), .buf_data_o(bdata), .buf_addr_o(baddr),
      .mac_addr_o(maddr), .mac_bit_o(mbit), .mac_strobe_o(strobe), .mac_pgm_en_o(pgm_en),
      .mac_sel_norm_o(s_norm), .mac_sel_red_o(s_red)
   );

   always @(posedge clk) begin
      #1;
      if (tcnt >= tper - 1) tcnt = 0; else tcnt = tcnt + 1;
      tick = (tcnt == 0);
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int nth_set(input logic [DW-1:0] d, input int k);
      int n = 0;
      for (int i = 0; i < DW; i++)
         if (d[i]) begin
            if (n == k) return i;
            n++;
         end
      return -1;
   endfunction

   task automatic close_seg(input int cls, input int cnt, input int seen, input int expn);
      int e;
      case (cls)
         1: begin e = (expn == 0) ? ts + th + 2 : ts + 1; chk(cnt == e, "R4/R10 setup", cnt, e); end
         2: begin e = tp + 1; chk(cnt == e, "R5/R10 pulse", cnt, e); end
         3: if (seen < expn) begin e = tg + 1; chk(cnt == e, "R6 gap", cnt, e); end
            else begin e = th + 1; chk(cnt == e, "R7 hold", cnt, e); end
         4: begin e = tr + 1; chk(cnt == e, "R8 recovery", cnt, e); end
         default: ;
      endcase
   endtask

   task automatic run_req(input logic [DW-1:0] d, input logic [AW-1:0] a, input logic [1:0] s,
                          input int vs, vp, vg, vh, vr, input bit poke);
      int prev = 0, cnt = 0, seen = 0, cyc = 0, cls, expn, eb;
      bit sel_ok = 1, held_ok = 1;
      expn = $countones(d);
      @(posedge clk); #2;
      ts = TW'(vs); tp = TW'(vp); tg = TW'(vg); th = TW'(vh); tr = TW'(vr);
      sel_v = s; wr_data = 1; data_v = d;
      @(posedge clk); #2;
      wr_data = 0; wr_addr = 1; addr_v = a;
      @(posedge clk); #2;
      wr_addr = 0; sel_v = ~s;   // launch already captured the code (R9)
      @(negedge clk);
      chk(!buf_empty && !idle && pgm_en, "R3 launch", {buf_empty, idle, pgm_en}, 3'b001);
      chk(bdata == d, "R2 data accepted", bdata, d);
      chk(maddr == a, "R11 address", maddr, a);
      while (1) begin
         if (idle) begin
            close_seg(prev, cnt, seen, expn);
            break;
         end
         if (strobe) cls = 2;
         else if (pgm_en) cls = (seen == 0) ? 1 : 3;
         else cls = 4;
         if (cls != prev) begin
            if (prev != 0) close_seg(prev, cnt, seen, expn);
            cnt = 0;
            if (cls == 2) begin
               eb = nth_set(d, seen);
               chk(int'(mbit) == eb, "R5 bit order", mbit, eb);
               seen++;
            end
         end
         if (tick) cnt++;
         if (pgm_en && (s_norm != (s != 2'd2) || s_red != (s != 2'd1))) sel_ok = 0;
         if (!pgm_en && (s_norm || s_red)) sel_ok = 0;
         if (bdata != d || baddr != a || maddr != a || buf_empty) held_ok = 0;
         if (poke && cyc == 2) begin
            wr_data = 1; data_v = ~d; wr_addr = 1; addr_v = ~a;
         end
         if (cyc == 3) begin wr_data = 0; wr_addr = 0; end
         prev = cls;
         cyc++;
         if (cyc > 40000) begin chk(0, "R8 sequence ends", cyc, 0); break; end
         @(negedge clk);
      end
      wr_data = 0; wr_addr = 0;
      chk(buf_empty && idle, "R8 flags return together", {buf_empty, idle}, 2'b11);
      chk(seen == expn, "R5 pulse count", seen, expn);
      chk(sel_ok, "R9 array select", {s_norm, s_red}, s);
      chk(held_ok, poke ? "R2 writes ignored while full" : "R11 buffer held", bdata, d);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual %0d expected <190000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0f7c));
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      chk(buf_empty && idle && !pgm_en && !strobe, "R1 reset state",
          {buf_empty, idle, pgm_en, strobe}, 4'b1100);

      // R3: no launch while the program mode is off
      @(posedge clk); #2; wr_data = 1; data_v = 32'h0000_00f0;
      @(posedge clk); #2; wr_data = 0; wr_addr = 1; addr_v = 13'h0a5;
      @(posedge clk); #2; wr_addr = 0;
      @(negedge clk);
      chk(idle && buf_empty && !pgm_en, "R3 no launch without mode", {idle, buf_empty, pgm_en}, 3'b110);
      chk(baddr == 13'h0a5, "R2 address accepted", baddr, 13'h0a5);
      prog_mode = 1;

      run_req(32'h0000_0005, 13'h010, 2'd0, 19, 15, 4, 9, 99, 0);   // realistic bounds
      run_req(32'h8000_0000, 13'h1ff, 2'd1, 3, 2, 1, 2, 3, 0);      // top bit only
      run_req(32'h0000_0000, 13'h002, 2'd2, 4, 1, 1, 5, 2, 0);      // R7 empty word
      run_req(32'hffff_ffff, 13'h003, 2'd3, 0, 0, 0, 0, 0, 1);      // every bit, poke R2
      tper = 3;                                                      // R10 sparse tick
      run_req(32'h8001_0100, 13'h004, 2'd3, 2, 3, 1, 1, 4, 1);
      for (int n = 0; n < 24; n++) begin
         tper = 1 + ($urandom % 3);
         run_req($urandom, 13'($urandom), 2'($urandom), $urandom % 4, $urandom % 4,
                 $urandom % 4, $urandom % 4, $urandom % 4, n[0]);
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule